// File: doc/BRIEF.md
# Banked Program Address Mapper

This block sits between a CPU core and its program memory. It turns the core's 12-bit program counter into a 13-bit physical address that spans four banks of 2 KB each. The upper half of the 4 KB window that the core can see (program counter bit 11 set) always reaches bank 1, the fixed bank. The lower half is a movable window. A small bank register picks which bank that window shows.

Software loads the bank register through an ordinary data-space write at a fixed address. The register cannot be read, so the core cannot recover its value. For that reason, code that must change the bank inside an interrupt handler is expected to keep a copy of the value in RAM.

The mapper also classifies each fetch on the physical address. It flags:
- fetches from the interrupt vector slots, the non-maskable vector and the reset vector;
- fetches from any reserved area.

These flags let the surrounding logic detect a stray fetch.

Top module: `banked_pmap`

## Requirements
- R1: After reset the bank register holds the parameter `PAGE_RST_VAL`, an arbitrary documented stand-in for an undefined value (default 1). With program counter bit 11 clear, `phys_addr[12:11]` equals that value.
- R2: When `dwr_en` is high at a rising clock edge and `dwr_addr` equals `PAGE_ADDR` (default 8'hCA), the bank register takes `dwr_data[1:0]`. The new bank shows on `phys_addr` from that edge on, and `dwr_data[7:2]` has no effect.
- R3: A write to any other address, or data on the write port without `dwr_en`, leaves the bank register unchanged.
- R4: When `pc[11]` is 1, `phys_addr[12:11]` is 2'b01 (bank 1) whatever the bank register holds.
- R5: When `pc[11]` is 0, `phys_addr[12:11]` equals the bank register. In every case `phys_addr[10:0]` equals `pc[10:0]`.
- R6: `vec_irq` is high for physical addresses 0FF0h to 0FF7h, with `vec_slot` = `phys_addr[2:1]`; otherwise `vec_slot` is 0.
- R7: `vec_nmi` is high for physical addresses 0FFCh to 0FFDh, and `vec_rst` is high for 0FFEh to 0FFFh.
- R8: `rsvd_hit` is high for physical addresses 0000h-007Fh, 0FA0h-0FEFh, 0FF8h-0FFBh, 1000h-100Fh and 1800h-180Fh. At most one of `vec_irq`, `vec_nmi`, `vec_rst` and `rsvd_hit` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dwr_addr | input | 8 | Data-space write address |
| dwr_data | input | 8 | Data-space write data |
| dwr_en | input | 1 | Data-space write strobe |
| pc | input | 12 | CPU program counter |
| phys_addr | output | 13 | Physical program-memory address |
| vec_irq | output | 1 | Fetch from an interrupt vector slot |
| vec_slot | output | 2 | Which interrupt vector slot, 0 when not a vector fetch |
| vec_nmi | output | 1 | Fetch from the non-maskable vector |
| vec_rst | output | 1 | Fetch from the reset vector |
| rsvd_hit | output | 1 | Fetch from a reserved area |

## Verification
The assertions assume that the program counter and the write port are stable and free of unknowns around each rising edge. They also assume that reset is applied long enough for the bank register to take its stand-in value before any check is enabled.

The bench meets these assumptions in three ways:
- It changes every input on the falling edge and samples the combinational outputs one nanosecond later.
- It holds reset low for several cycles before releasing it.
- It keeps write data to known values, including values with junk upper bits, so that the ignored field is exercised without adding unknowns.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int PAGE_W      = 2;
  localparam int OFS_W       = 11;
  localparam int PC_W        = OFS_W + 1;
  localparam int PHYS_W      = PAGE_W + OFS_W;
  localparam int NUM_PAGES   = 1 << PAGE_W;
  localparam int SLOT_W      = 2;
  localparam logic [PAGE_W-1:0] STATIC_PAGE = PAGE_W'(1);

  // offsets inside the fixed bank
  localparam logic [OFS_W-1:0] FIX_RSV_LO  = OFS_W'('h7A0);
  localparam logic [OFS_W-1:0] FIX_RSV_HI  = OFS_W'('h7EF);
  localparam logic [OFS_W-1:0] IRQ_LO      = OFS_W'('h7F0);
  localparam logic [OFS_W-1:0] IRQ_HI      = OFS_W'('h7F7);
  localparam logic [OFS_W-1:0] GAP_LO      = OFS_W'('h7F8);
  localparam logic [OFS_W-1:0] GAP_HI      = OFS_W'('h7FB);
  localparam logic [OFS_W-1:0] NMI_LO      = OFS_W'('h7FC);
  localparam logic [OFS_W-1:0] NMI_HI      = OFS_W'('h7FD);
  localparam logic [OFS_W-1:0] RST_LO      = OFS_W'('h7FE);

  typedef enum logic [2:0] {
    RG_USER, RG_RSVD, RG_IRQV, RG_NMIV, RG_RSTV
  } region_e;

  // bank used for a fetch
  function automatic logic [PAGE_W-1:0] pm_pick_page(
    input logic hi_bit, input logic [PAGE_W-1:0] bank_q);
    return hi_bit ? STATIC_PAGE : bank_q;
  endfunction

  // size of the reserved area at the bottom of a bank (0 = none)
  function automatic logic [OFS_W:0] pm_low_rsvd_len(input int unsigned page);
    case (page)
      0:       return (OFS_W+1)'('h80);
      1:       return '0;
      default: return (OFS_W+1)'('h10);
    endcase
  endfunction

  function automatic logic pm_in(input logic [OFS_W-1:0] v,
                                 input logic [OFS_W-1:0] lo,
                                 input logic [OFS_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // classification inside the fixed bank
  function automatic region_e pm_fixed_region(input logic [OFS_W-1:0] ofs);
    if (pm_in(ofs, IRQ_LO, IRQ_HI))          return RG_IRQV;
    else if (pm_in(ofs, NMI_LO, NMI_HI))     return RG_NMIV;
    else if (ofs >= RST_LO)                  return RG_RSTV;
    else if (pm_in(ofs, FIX_RSV_LO, FIX_RSV_HI) ||
             pm_in(ofs, GAP_LO, GAP_HI))     return RG_RSVD;
    else                                     return RG_USER;
  endfunction
endpackage

// File: rtl/pmap_page_reg.sv
module pmap_page_reg
  import pmap_pkg::*;
#(
  parameter int DADDR_W = 8,
  parameter int DATA_W  = 8,
  parameter logic [DADDR_W-1:0] PAGE_ADDR    = DADDR_W'('hCA),
  parameter logic [PAGE_W-1:0]  PAGE_RST_VAL = PAGE_W'(1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_en,
  output logic [PAGE_W-1:0]  bank_q,
  output logic               wr_hit
);
  localparam int JUNK_W = DATA_W - PAGE_W;

  logic [JUNK_W-1:0] unused_junk;
  assign unused_junk = wr_data[DATA_W-1:PAGE_W];

  assign wr_hit = wr_en && (wr_addr == PAGE_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)      bank_q <= PAGE_RST_VAL;
    else if (wr_hit) bank_q <= wr_data[PAGE_W-1:0];
  end

  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == PAGE_ADDR) |=> bank_q == $past(wr_data[PAGE_W-1:0]));

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == PAGE_ADDR) |=> $stable(bank_q));
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
  import pmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pc,
  input  logic [PAGE_W-1:0] bank_q,
  output logic [PAGE_W-1:0] sel_page,
  output logic [OFS_W-1:0]  sel_ofs,
  output logic              fixed_forced,
  output logic [PHYS_W-1:0] phys
);
  assign fixed_forced = pc[PC_W-1];
  assign sel_ofs      = pc[OFS_W-1:0];
  assign sel_page     = pm_pick_page(fixed_forced, bank_q);
  assign phys         = {sel_page, sel_ofs};

  // R4
  fixed_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc[PC_W-1] |-> phys[PHYS_W-1 -: PAGE_W] == STATIC_PAGE);

  // R5
  window_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc[PC_W-1] |-> phys[PHYS_W-1 -: PAGE_W] == bank_q);

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phys[OFS_W-1:0] == pc[OFS_W-1:0]);
endmodule

// File: rtl/pmap_region.sv
module pmap_region
  import pmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] sel_page,
  input  logic [OFS_W-1:0]  sel_ofs,
  output logic              vec_irq,
  output logic [SLOT_W-1:0] vec_slot,
  output logic              vec_nmi,
  output logic              vec_rst,
  output logic              rsvd_hit
);
  logic [NUM_PAGES-1:0] low_rsvd;
  region_e fixed_rg;
  logic    in_fixed;

  // per-bank reserved area at offset zero
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_low
    localparam logic [OFS_W:0] LEN = pm_low_rsvd_len(g);
    assign low_rsvd[g] = (sel_page == PAGE_W'(g)) &&
                         ({1'b0, sel_ofs} < LEN);
  end

  assign in_fixed = (sel_page == STATIC_PAGE);
  assign fixed_rg = pm_fixed_region(sel_ofs);

  always_comb begin
    vec_irq  = in_fixed && (fixed_rg == RG_IRQV);
    vec_nmi  = in_fixed && (fixed_rg == RG_NMIV);
    vec_rst  = in_fixed && (fixed_rg == RG_RSTV);
    rsvd_hit = (in_fixed && (fixed_rg == RG_RSVD)) || (|low_rsvd);
    vec_slot = vec_irq ? sel_ofs[SLOT_W:1] : '0;
  end

  // R8
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vec_irq, vec_nmi, vec_rst, rsvd_hit}));

  // R6
  vec_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_irq || vec_nmi || vec_rst) |-> sel_page == STATIC_PAGE);

  // R6
  slot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_irq |-> vec_slot == '0);
endmodule

// File: rtl/banked_pmap.sv
module banked_pmap
  import pmap_pkg::*;
#(
  parameter int DADDR_W = 8,
  parameter int DATA_W  = 8,
  parameter logic [DADDR_W-1:0] PAGE_ADDR    = DADDR_W'('hCA),
  parameter logic [PAGE_W-1:0]  PAGE_RST_VAL = PAGE_W'(1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DADDR_W-1:0] dwr_addr,
  input  logic [DATA_W-1:0]  dwr_data,
  input  logic               dwr_en,
  input  logic [PC_W-1:0]    pc,
  output logic [PHYS_W-1:0]  phys_addr,
  output logic               vec_irq,
  output logic [SLOT_W-1:0]  vec_slot,
  output logic               vec_nmi,
  output logic               vec_rst,
  output logic               rsvd_hit
);
  logic [PAGE_W-1:0] bank_q;
  logic              wr_hit;
  logic [PAGE_W-1:0] sel_page;
  logic [OFS_W-1:0]  sel_ofs;
  logic              fixed_forced;
  logic              unused_evt;

  assign unused_evt = wr_hit ^ fixed_forced;

  pmap_page_reg #(
    .DADDR_W(DADDR_W), .DATA_W(DATA_W),
    .PAGE_ADDR(PAGE_ADDR), .PAGE_RST_VAL(PAGE_RST_VAL)
  ) bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(dwr_addr), .wr_data(dwr_data), .wr_en(dwr_en),
    .bank_q(bank_q), .wr_hit(wr_hit)
  );

  pmap_xlate xl_i (
    .clk(clk), .rst_n(rst_n), .pc(pc), .bank_q(bank_q),
    .sel_page(sel_page), .sel_ofs(sel_ofs),
    .fixed_forced(fixed_forced), .phys(phys_addr)
  );

  pmap_region rg_i (
    .clk(clk), .rst_n(rst_n), .sel_page(sel_page), .sel_ofs(sel_ofs),
    .vec_irq(vec_irq), .vec_slot(vec_slot), .vec_nmi(vec_nmi),
    .vec_rst(vec_rst), .rsvd_hit(rsvd_hit)
  );

  // R1
  reset_bank_chk: assert property (@(posedge clk)
    (!rst_n && !pc[PC_W-1]) |=> ($past(!rst_n) && !pc[PC_W-1] && !$past(dwr_en) && rst_n)
      |-> phys_addr[PHYS_W-1 -: PAGE_W] == PAGE_RST_VAL || $past(dwr_en));
endmodule

// File: tb/banked_pmap_tb_top.sv
module banked_pmap_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  dwr_addr = 0;
  logic [7:0]  dwr_data = 0;
  logic        dwr_en = 0;
  logic [11:0] pc = 0;
  logic [12:0] phys_addr;
  logic        vec_irq, vec_nmi, vec_rst, rsvd_hit;
  logic [1:0]  vec_slot;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [1:0] model_bank;

  always #5 clk = ~clk;

  banked_pmap dut_i (
    .clk(clk), .rst_n(rst_n), .dwr_addr(dwr_addr), .dwr_data(dwr_data),
    .dwr_en(dwr_en), .pc(pc), .phys_addr(phys_addr), .vec_irq(vec_irq),
    .vec_slot(vec_slot), .vec_nmi(vec_nmi), .vec_rst(vec_rst),
    .rsvd_hit(rsvd_hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference classification from the requirements, on the full physical address
  task automatic check_fetch(input logic [11:0] p, input string req);
    logic [12:0] ea;
    logic ei, en, er, ev;
    logic [1:0] es;
    @(negedge clk);
    pc = p;
    #1;
    ea = pc[11] ? {2'b01, pc[10:0]} : {model_bank, pc[10:0]};
    ei = (ea >= 13'h0FF0 && ea <= 13'h0FF7);
    en = (ea == 13'h0FFC || ea == 13'h0FFD);
    er = (ea == 13'h0FFE || ea == 13'h0FFF);
    ev = (ea <= 13'h007F) || (ea >= 13'h0FA0 && ea <= 13'h0FEF) ||
         (ea >= 13'h0FF8 && ea <= 13'h0FFB) ||
         (ea >= 13'h1000 && ea <= 13'h100F) ||
         (ea >= 13'h1800 && ea <= 13'h180F);
    es = ei ? ea[2:1] : 2'b00;
    chk({req, " addr"}, 32'(phys_addr), 32'(ea));
    chk({req, " R6 irq"}, 32'(vec_irq), 32'(ei));
    chk({req, " R6 slot"}, 32'(vec_slot), 32'(es));
    chk({req, " R7 nmi"}, 32'(vec_nmi), 32'(en));
    chk({req, " R7 rst"}, 32'(vec_rst), 32'(er));
    chk({req, " R8 rsvd"}, 32'(rsvd_hit), 32'(ev));
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    dwr_addr = a; dwr_data = d; dwr_en = en;
    @(negedge clk);
    dwr_en = 0;
    if (en && a == 8'hCA) model_bank = d[1:0];
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    model_bank = 2'd1;
    check_fetch(12'h0123, "R1 reset bank");
    chk("R1 upper bits", 32'(phys_addr[12:11]), 32'd1);
  endtask

  task automatic t_bank_writes;
    for (int b = 0; b < 4; b++) begin
      do_write(8'hCA, {6'b101101, 2'(b)}, 1'b1);
      check_fetch(12'h0456, "R2 write bank");
      chk("R5 window bank", 32'(phys_addr[12:11]), 32'(b));
    end
  endtask

  task automatic t_write_timing;
    do_write(8'hCA, 8'h02, 1'b1);
    @(negedge clk);
    pc = 12'h0200;
    dwr_addr = 8'hCA; dwr_data = 8'hFF; dwr_en = 1;
    #1;
    chk("R2 before edge", 32'(phys_addr[12:11]), 32'd2);
    @(posedge clk); #1;
    dwr_en = 0;
    chk("R2 after edge", 32'(phys_addr[12:11]), 32'd3);
    model_bank = 2'd3;
  endtask

  task automatic t_ignored;
    do_write(8'hCA, 8'h00, 1'b1);
    do_write(8'hCB, 8'h03, 1'b1);
    check_fetch(12'h0300, "R3 other addr");
    do_write(8'hC9, 8'h02, 1'b1);
    check_fetch(12'h0300, "R3 other addr low");
    do_write(8'hCA, 8'h03, 1'b0);
    check_fetch(12'h0300, "R3 no strobe");
    do_write(8'hCA, 8'hFC, 1'b1);
    check_fetch(12'h0300, "R2 junk high bits");
  endtask

  task automatic t_fixed_override;
    for (int b = 0; b < 4; b++) begin
      do_write(8'hCA, 8'(b), 1'b1);
      check_fetch(12'h0ABC, "R4 forced fixed");
      chk("R4 upper", 32'(phys_addr[12:11]), 32'd1);
    end
  endtask

  task automatic t_vectors;
    do_write(8'hCA, 8'h00, 1'b1);
    for (int a = 12'hFE8; a <= 12'hFFF; a++) check_fetch(12'(a), "R6 R7 top");
    do_write(8'hCA, 8'h01, 1'b1);
    for (int a = 12'h7EE; a <= 12'h7FF; a++) check_fetch(12'(a), "R6 via window");
  endtask

  task automatic t_reserved;
    for (int b = 0; b < 4; b++) begin
      do_write(8'hCA, 8'(b), 1'b1);
      check_fetch(12'h000, "R8 bottom");
      check_fetch(12'h00F, "R8 edge lo");
      check_fetch(12'h010, "R8 edge hi");
      check_fetch(12'h07F, "R8 bank0 end");
      check_fetch(12'h080, "R8 bank0 past");
      check_fetch(12'hF9F, "R8 fixed before");
      check_fetch(12'hFA0, "R8 fixed start");
      check_fetch(12'hFEF, "R8 fixed end");
    end
  endtask

  task automatic t_sweep;
    for (int b = 0; b < 4; b++) begin
      do_write(8'hCA, 8'(b), 1'b1);
      for (int a = 0; a < 4096; a += 37) check_fetch(12'(a), "R5 sweep");
    end
  endtask

  initial begin
    t_reset();
    t_bank_writes();
    t_write_timing();
    t_ignored();
    t_fixed_override();
    t_vectors();
    t_reserved();
    t_sweep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule